// File: doc/BRIEF.md
# Gather Address Cacheline Coalescer

This block takes one SIMD gather or scatter request of up to sixteen lanes and turns it into the fewest 64-byte cacheline requests that cover every active lane. Each lane presents a byte address for a 32-bit element and an active bit. The block groups the active lanes by the cacheline they fall in and issues one line request per distinct line. It never issues the same line twice within one request.

Each line request carries the line-aligned address, a sixteen-bit mask of the lanes that the line serves, and every lane's dword position inside the line. A return path can use these to steer the data of that line back to the right lanes. The block works one line per clock cycle. While a request is still being split it holds off new requests. It raises a completion pulse together with the final line. A request with no active lanes finishes in a single cycle and issues no line at all.

Top module: `gather_line_coalescer`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `line_valid` is 0 and `done` is 0.
- R2: `line_addr` equals the byte address of a lane in `line_mask`, with its low 6 bits forced to zero.
- R3: `line_mask` bit i is 1 exactly when lane i is active, is not yet covered by an earlier line of the same request, and its address lies in the line `line_addr`.
- R4: Within one request no line address is issued twice. The number of lines equals the number of distinct cachelines among the active lanes.
- R5: Each line is chosen by the lowest-numbered active lane not yet covered, so each line's lowest mask bit lies above the previous line's lowest mask bit.
- R6: Once a request with active lanes is accepted, line requests appear on consecutive cycles, starting in the cycle after acceptance, with no gap until the last.
- R7: `line_offs` bits [4i+3:4i] hold bits [5:2] of lane i's address, which is its dword position inside the line.
- R8: If all active lanes fall in one cacheline, exactly one line is issued, and `done` is high with it.
- R9: `done` is 1 in the cycle of the final line of a request, and 0 during every earlier line.
- R10: `req_ready` is 0 during every non-final line, so a request offered then is ignored. `req_ready` is 1 during the final line, so the next request can be accepted in that same cycle.
- R11: A request whose active mask is all zeros issues no line. It gives a one-cycle `done` pulse in the cycle after acceptance, with `line_valid` low.
- R12: The addresses of inactive lanes have no effect on the lines issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_active | input | LANES (16) | Per-lane active bits |
| req_addr | input | LANES*ADDR_W (512) | Lane byte addresses, lane i at bits [32i+31:32i] |
| req_ready | output | 1 | A request offered now is accepted at the next edge |
| line_valid | output | 1 | A line request is presented |
| line_addr | output | ADDR_W (32) | Line-aligned byte address |
| line_mask | output | LANES (16) | Lanes served by this line |
| line_offs | output | LANES*4 (64) | Per-lane dword offset within the line |
| done | output | 1 | Final line of a request, or completion of an empty request |

## Verification
Two functions can fall in the same cycle: issuing the final line of one request, with its `done` pulse, and accepting the next request. The bench provokes this by offering the next request in the very cycle it expects the final line. It then checks that the old request's last line and done are intact, and that the new request's first line follows in the next cycle with no idle gap. The same is done after an empty request, whose `done` pulse cycle must also accept a follow-on request. While lines are still pending, the bench holds `req_valid` high with random content to confirm that nothing is taken in early.

// File: rtl/coalesce_pkg.sv
// Package: coalesce_pkg
// Shared default geometry for the gather line coalescer.
// Assumes power-of-two line and element sizes.
package coalesce_pkg;
    parameter int unsigned DEF_LANES      = 16;
    parameter int unsigned DEF_ADDR_W     = 32;
    parameter int unsigned DEF_LINE_BYTES = 64;
    parameter int unsigned DEF_ELEM_BYTES = 4;
endpackage

// File: rtl/coalesce_lane_picker.sv
// Module: coalesce_lane_picker
// Finds the lowest-numbered lane still pending. This lane picks the
// cacheline for the current cycle.
// Assumes: a caller ignores the result when no lane is pending (the index is 0 then).
module coalesce_lane_picker #(
    parameter int unsigned LANES = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic [LANES-1:0] pend,
    output logic [IDX_W-1:0] lead_idx
);
    // Priority search, lowest lane wins.
    always_comb begin
        lead_idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) lead_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/coalesce_line_matcher.sv
// Module: coalesce_line_matcher
// Takes the line tag of the lead lane. It builds the aligned line
// address and marks every pending lane whose address lies in that line.
// Assumes: lead_idx names a pending lane whenever the result is used.
module coalesce_line_matcher #(
    parameter int unsigned LANES      = 16,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_SHIFT = 6,
    parameter int unsigned IDX_W      = 4
) (
    input  logic [LANES*ADDR_W-1:0] addrs,
    input  logic [LANES-1:0]        pend,
    input  logic [IDX_W-1:0]        lead_idx,
    output logic [ADDR_W-1:0]       line_addr,
    output logic [LANES-1:0]        hits
);
    localparam int unsigned TAG_W = ADDR_W - LINE_SHIFT;

    logic [TAG_W-1:0] lead_tag;
    int unsigned      lead_base;

    // Select the lead lane's tag.
    always_comb begin
        lead_base = 32'(lead_idx) * ADDR_W;
        lead_tag  = addrs[lead_base + LINE_SHIFT +: TAG_W];
    end

    assign line_addr = {lead_tag, {LINE_SHIFT{1'b0}}};

    // One tag comparator per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        logic lsb_unused;
        assign lsb_unused = ^addrs[g*ADDR_W +: LINE_SHIFT];
        assign hits[g] = pend[g] &&
                         (addrs[g*ADDR_W + LINE_SHIFT +: TAG_W] == lead_tag);
    end
endmodule

// File: rtl/gather_line_coalescer.sv
// Module: gather_line_coalescer
// Splits one SIMD gather/scatter request into one request per distinct
// cacheline, one line per cycle. The lowest pending lane leads each line.
// Assumes: lane addresses are element aligned (bits below the element
// size do not matter). Synchronous active-low reset.
module gather_line_coalescer
    import coalesce_pkg::*;
#(
    parameter int unsigned LANES      = DEF_LANES,
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
    parameter int unsigned ELEM_BYTES = DEF_ELEM_BYTES
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              req_valid,
    input  logic [LANES-1:0]                                  req_active,
    input  logic [LANES*ADDR_W-1:0]                           req_addr,
    output logic                                              req_ready,
    output logic                                              line_valid,
    output logic [ADDR_W-1:0]                                 line_addr,
    output logic [LANES-1:0]                                  line_mask,
    output logic [LANES*$clog2(LINE_BYTES/ELEM_BYTES)-1:0]    line_offs,
    output logic                                              done
);
    localparam int unsigned LINE_SHIFT = $clog2(LINE_BYTES);
    localparam int unsigned ELEM_SHIFT = $clog2(ELEM_BYTES);
    localparam int unsigned OFF_W      = LINE_SHIFT - ELEM_SHIFT;
    localparam int unsigned IDX_W      = (LANES > 1) ? $clog2(LANES) : 1;

    logic                    busy_q;
    logic                    empty_q;
    logic [LANES-1:0]        pend_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]        lead_idx;
    logic [LANES-1:0]        hits;
    logic                    last_line;
    logic                    accept;

    coalesce_lane_picker #(
        .LANES (LANES),
        .IDX_W (IDX_W)
    ) i_picker (
        .pend     (pend_q),
        .lead_idx (lead_idx)
    );

    coalesce_line_matcher #(
        .LANES      (LANES),
        .ADDR_W     (ADDR_W),
        .LINE_SHIFT (LINE_SHIFT),
        .IDX_W      (IDX_W)
    ) i_matcher (
        .addrs     (addr_q),
        .pend      (pend_q),
        .lead_idx  (lead_idx),
        .line_addr (line_addr),
        .hits      (hits)
    );

    // Handshake and completion decode.
    always_comb begin
        last_line  = busy_q && ((pend_q & ~hits) == '0);
        req_ready  = !busy_q || last_line;
        accept     = req_valid && req_ready;
        line_valid = busy_q;
        line_mask  = busy_q ? hits : '0;
        done       = last_line || empty_q;
    end

    // Per-lane dword offset within the line.
    for (genvar g = 0; g < LANES; g++) begin : g_off
        assign line_offs[g*OFF_W +: OFF_W] = addr_q[g*ADDR_W + ELEM_SHIFT +: OFF_W];
    end

    // Request capture and per-cycle retirement of covered lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            empty_q <= 1'b0;
            pend_q  <= '0;
            addr_q  <= '0;
        end else begin
            empty_q <= accept && (req_active == '0);
            if (accept) begin
                addr_q <= req_addr;
                pend_q <= req_active;
                busy_q <= |req_active;
            end else if (busy_q) begin
                pend_q <= pend_q & ~hits;
                busy_q <= !last_line;
            end
        end
    end
endmodule

// File: rtl/coalescer_checker.sv
// Module: coalescer_checker
// Protocol properties of gather_line_coalescer, seen at its ports only.
// Assumes: bound to every instance of the coalescer.
module coalescer_checker #(
    parameter int unsigned LANES  = 16,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LINE_SHIFT = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [LANES-1:0]  req_active,
    input logic              req_ready,
    input logic              line_valid,
    input logic [ADDR_W-1:0] line_addr,
    input logic [LANES-1:0]  line_mask,
    input logic              done
);
    logic [LANES-1:0] prev_low;

    // Lowest set bit of the previous cycle's mask.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_low <= '0;
        else        prev_low <= line_mask & (~line_mask + 1'b1);
    end

    assert_mask_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> (line_mask != '0));

    assert_line_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> (line_addr[LINE_SHIFT-1:0] == '0));

    assert_no_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !done) |=>
            (((line_mask & $past(line_mask)) == '0) && (line_addr != $past(line_addr))));

    assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !done) |=> ((line_mask & ((prev_low << 1) - 1'b1)) == '0));

    assert_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !done) |=> line_valid);

    assert_hold_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !done) |-> !req_ready);

    assert_empty_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_active == '0)) |=> (done && !line_valid));
endmodule

bind gather_line_coalescer coalescer_checker #(
    .LANES      (LANES),
    .ADDR_W     (ADDR_W),
    .LINE_SHIFT (LINE_SHIFT)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_active (req_active),
    .req_ready  (req_ready),
    .line_valid (line_valid),
    .line_addr  (line_addr),
    .line_mask  (line_mask),
    .done       (done)
);

// File: tb/test_gather_line_coalescer.sv
// Bench for gather_line_coalescer: table-driven patterns, then directed cases.
module test_gather_line_coalescer;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 16;
    localparam int AW    = 32;

    typedef struct packed {
        logic [15:0] act;
        logic [31:0] base;
        logic [31:0] stride;
        logic [31:0] wrap;
        logic [7:0]  n_lines;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'hFFFF, 32'h0000_1000, 32'd4,         32'hFFFF_FFFF, 8'd1},
        '{16'hFFFF, 32'h0000_2000, 32'd64,        32'hFFFF_FFFF, 8'd16},
        '{16'hFFFF, 32'h0000_3000, 32'd8,         32'hFFFF_FFFF, 8'd2},
        '{16'hAAAA, 32'h0000_4000, 32'd4,         32'hFFFF_FFFF, 8'd1},
        '{16'h8001, 32'h0000_5000, 32'd16,        32'hFFFF_FFFF, 8'd2},
        '{16'hFFFF, 32'h0000_103C, 32'd4,         32'hFFFF_FFFF, 8'd2},
        '{16'hFFFF, 32'h0000_8000, 32'hFFFF_FFC0, 32'hFFFF_FFFF, 8'd16},
        '{16'hFFFF, 32'h0000_6000, 32'd64,        32'h0000_00FF, 8'd4},
        '{16'hFFFF, 32'h0000_7004, 32'd0,         32'hFFFF_FFFF, 8'd1},
        '{16'h0F0F, 32'h0000_9FFC, 32'd4,         32'hFFFF_FFFF, 8'd2}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [LANES-1:0]  req_active = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic              req_ready;
    logic              line_valid;
    logic [AW-1:0]     line_addr;
    logic [LANES-1:0]  line_mask;
    logic [LANES*4-1:0] line_offs;
    logic              done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gather_line_coalescer i_gather_line_coalescer (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_active (req_active),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .line_valid (line_valid),
        .line_addr  (line_addr),
        .line_mask  (line_mask),
        .line_offs  (line_offs),
        .done       (done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [LANES*AW-1:0] build(input vec_t v);
        logic [LANES*AW-1:0] a;
        for (int i = 0; i < LANES; i++)
            a[i*AW +: AW] = v.base + ((32'(i) * v.stride) & v.wrap);
        return a;
    endfunction

    task automatic garble_inputs();
        req_valid  = 1'b1;
        req_active = 16'($urandom);
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = $urandom;
    endtask

    // Called at a negedge; leaves the bench at the negedge of the final line
    // (or of the done pulse for an empty request).
    task automatic run_req(input logic [15:0] act, input logic [LANES*AW-1:0] addrs,
                           input int exp_n, input string tag);
        logic [15:0] pend;
        logic [15:0] m;
        logic [31:0] line;
        int lo;
        int n;
        bit last;
        chk(req_ready === 1'b1, {"R10 ready before accept ", tag}, 64'(req_ready), 64'd1);
        req_valid  = 1'b1;
        req_active = act;
        req_addr   = addrs;
        @(posedge clk);
        @(negedge clk);
        if (act == '0) begin
            req_valid = 1'b0;
            chk(done === 1'b1 && line_valid === 1'b0, {"R11 empty done pulse ", tag},
                64'({done, line_valid}), 64'b10);
            return;
        end
        pend = act;
        n = 0;
        while (pend != '0) begin
            lo = 0;
            for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lo = i;
            line = addrs[lo*AW +: AW] & 32'hFFFF_FFC0;
            m = '0;
            for (int i = 0; i < LANES; i++)
                if (pend[i] && ((addrs[i*AW +: AW] & 32'hFFFF_FFC0) == line)) m[i] = 1'b1;
            pend = pend & ~m;
            n++;
            last = (pend == '0);
            chk(line_valid === 1'b1, {"R6 line valid ", tag}, 64'(line_valid), 64'd1);
            chk(line_addr === line, {"R2 R5 line address ", tag}, 64'(line_addr), 64'(line));
            chk(line_mask === m, {"R3 R12 lane mask ", tag}, 64'(line_mask), 64'(m));
            for (int i = 0; i < LANES; i++)
                if (m[i])
                    chk(line_offs[i*4 +: 4] === addrs[i*AW + 2 +: 4], {"R7 dword offset ", tag},
                        64'(line_offs[i*4 +: 4]), 64'(addrs[i*AW + 2 +: 4]));
            chk(done === last, {"R9 done timing ", tag}, 64'(done), 64'(last));
            chk(req_ready === last, {"R10 ready during lines ", tag}, 64'(req_ready), 64'(last));
            if (!last) begin
                garble_inputs();
                @(negedge clk);
            end else begin
                req_valid = 1'b0;
            end
        end
        if (exp_n >= 0)
            chk(n == exp_n, {"R4 R8 line count ", tag}, 64'(n), 64'(exp_n));
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        chk(line_valid === 1'b0 && done === 1'b0 && req_ready === 1'b1,
            {"R1 R10 idle after request ", tag}, 64'({line_valid, done, req_ready}), 64'b001);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [LANES*AW-1:0] a;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && line_valid === 1'b0 && done === 1'b0, "R1 in reset",
            64'({req_ready, line_valid, done}), 64'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && line_valid === 1'b0 && done === 1'b0, "R1 after reset",
            64'({req_ready, line_valid, done}), 64'b100);

        // Table walk; inactive lanes get random addresses (R12).
        for (int v = 0; v < NV; v++) begin
            a = build(VECS[v]);
            for (int i = 0; i < LANES; i++)
                if (!VECS[v].act[i]) a[i*AW +: AW] = $urandom;
            run_req(VECS[v].act, a, int'(VECS[v].n_lines), $sformatf("vec%0d", v));
            idle_check($sformatf("vec%0d", v));
        end

        // R11: empty request, then idle.
        run_req(16'h0000, build(VECS[1]), 0, "empty");
        idle_check("empty");

        // R11 + R10: empty request directly followed by a real one in the pulse cycle.
        run_req(16'h0000, build(VECS[0]), 0, "empty-chain");
        run_req(16'hFFFF, build(VECS[7]), 4, "after-empty");
        // R10: next request accepted in the final-line cycle, no gap (R6).
        run_req(16'hFFFF, build(VECS[2]), 2, "chained");
        run_req(16'h00F0, build(VECS[1]), 4, "chained2");
        idle_check("chained2");

        // R8: single active lane at the top of a line.
        a = build(VECS[0]);
        a[15*AW +: AW] = 32'hFFFF_FFFC;
        run_req(16'h8000, a, 1, "top-lane");
        idle_check("top-lane");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule